// File: doc/BRIEF.md
# Floating-Point Status Word Register

This block keeps the 16-bit status word of a floating-point unit and the six exception masks of its control word. The execution unit reports each instruction's outcome through an update port: exception flags to merge in, a stack-fault indication, new condition codes and a new top-of-stack pointer. Software-driven operations reach the block as three commands: a whole-word load (used by environment restore), a clear-exceptions command and an initialise command.

The exception flags are sticky. An update can set them but never clears them. The error-summary bit, the busy-compatibility bit and the active-low error pin are not stored. They are always derived from the flags currently held and the masks currently held. A whole-word load therefore cannot force the summary state: whatever the loaded data holds in those two positions is discarded. If the loaded flags contain an unmasked exception, the error pin asserts as soon as the word is written.

Top module: `fp_status_reg`

## Requirements
- R1: After reset, and after the cycle that follows an `init` command, the status word reads 0x0000, all six masks are 1 and `err_n` is high.
- R2: An update ORs `upd_exc[5:0]` into status bits 5..0. Once a flag is set, it stays set through later updates.
- R3: An update with `upd_stack_fault` high sets bit 6 (stack fault) and bit 0 (invalid operation). In that update the C1 bit (bit 9) takes `upd_cc[1]`: 1 means overflow and 0 means underflow.
- R4: An update with `upd_cc_we` high writes `upd_cc[3:0]` = {C3,C2,C1,C0} to bits 14, 10, 9 and 8. With `upd_cc_we` low, those bits keep their values.
- R5: An update with `upd_top_we` high writes `upd_top` to bits 13..11. Otherwise TOP keeps its value.
- R6: Bit 7 (ES) is 1 exactly when some flag i in bits 5..0 is set while mask bit i is 0.
- R7: Bit 15 always equals bit 7.
- R8: `err_n` is low exactly when ES is 1, and it changes in the same cycle as the status word.
- R9: A load writes bits 14..8 and 6..0 from `ld_word`. Bits 15 and 7 of `ld_word` are ignored, and ES and B are recomputed from the loaded flags and the held masks.
- R10: Clear-exceptions zeroes bits 6..0. TOP and the condition codes are kept, so ES, B and the error pin all go inactive.
- R11: When commands arrive in the same cycle, the priority is init, then load, then clear, then update. Every lower-priority command in that cycle is dropped.
- R12: A mask write (`mask_we`) takes effect at the next edge and re-evaluates ES with no further delay. It leaves bits 6..0 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| init | input | 1 | Initialise command |
| ld_valid | input | 1 | Whole-word load strobe |
| ld_word | input | 16 | Data for the whole-word load |
| clr_exc | input | 1 | Clear-exceptions command |
| upd_valid | input | 1 | Execution-unit report strobe |
| upd_exc | input | 6 | Exception flags to merge in |
| upd_stack_fault | input | 1 | Stack fault report |
| upd_cc_we | input | 1 | Condition-code write enable |
| upd_cc | input | 4 | New {C3,C2,C1,C0} |
| upd_top_we | input | 1 | Top-of-stack write enable |
| upd_top | input | 3 | New top-of-stack pointer |
| mask_we | input | 1 | Exception-mask write enable |
| mask_in | input | 6 | Control-word mask bits 5..0 |
| status_word | output | 16 | Status word read port |
| err_n | output | 1 | Error pin, active low |

## Verification
The bench builds the block with its default parameters: six exception flags and a 3-bit top-of-stack pointer. With that size, every pairing of the 64 flag patterns with the 64 mask patterns can be applied through the load port, and the summary bit, the B bit and the error pin are checked for each pairing. Directed sequences then cover sticky accumulation, stack-fault reporting, partial field updates, clearing and the command priority order.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
  localparam int unsigned FSW_EXC_N = 6;
  localparam int unsigned FSW_TOP_W = 3;

  typedef enum logic [2:0] {
    FSW_IDLE,
    FSW_INIT,
    FSW_LOAD,
    FSW_CLEAR,
    FSW_UPDATE
  } fsw_cmd_e;

  // strict priority: init > load > clear > update
  function automatic fsw_cmd_e fsw_pick(input logic i, input logic l,
                                        input logic c, input logic u);
    if (i)      return FSW_INIT;
    else if (l) return FSW_LOAD;
    else if (c) return FSW_CLEAR;
    else if (u) return FSW_UPDATE;
    else        return FSW_IDLE;
  endfunction
endpackage

// File: rtl/fsw_flag_bank.sv
module fsw_flag_bank
  import fsw_pkg::*;
#(
  parameter int unsigned NUM_EXC = FSW_EXC_N
) (
  input  logic               clk,
  input  logic               rst_n,
  input  fsw_cmd_e           cmd,
  input  logic [NUM_EXC-1:0] upd_exc,
  input  logic               upd_sf,
  input  logic [NUM_EXC-1:0] ld_flags,
  input  logic               ld_sf,
  output logic [NUM_EXC-1:0] flags,
  output logic               sf
);
  logic [NUM_EXC-1:0] set_vec;

  // a stack fault also raises the invalid-operation flag (bit 0)
  always_comb begin
    set_vec    = upd_exc;
    set_vec[0] = upd_exc[0] | upd_sf;
  end

  for (genvar g = 0; g < NUM_EXC; g++) begin : g_cell
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[g] <= 1'b0;
      else begin
        case (cmd)
          FSW_INIT, FSW_CLEAR: flags[g] <= 1'b0;
          FSW_LOAD:            flags[g] <= ld_flags[g];
          FSW_UPDATE:          if (set_vec[g]) flags[g] <= 1'b1;
          default:             ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sf <= 1'b0;
    else begin
      case (cmd)
        FSW_INIT, FSW_CLEAR: sf <= 1'b0;
        FSW_LOAD:            sf <= ld_sf;
        FSW_UPDATE:          if (upd_sf) sf <= 1'b1;
        default:             ;
      endcase
    end
  end
endmodule

// File: rtl/fsw_field_regs.sv
module fsw_field_regs
  import fsw_pkg::*;
#(
  parameter int unsigned TOP_W = FSW_TOP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  fsw_cmd_e         cmd,
  input  logic             upd_cc_we,
  input  logic [3:0]       upd_cc,
  input  logic             upd_top_we,
  input  logic [TOP_W-1:0] upd_top,
  input  logic [3:0]       ld_cc,
  input  logic [TOP_W-1:0] ld_top,
  output logic [3:0]       cc,
  output logic [TOP_W-1:0] top
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cc  <= '0;
      top <= '0;
    end else begin
      case (cmd)
        FSW_INIT: begin
          cc  <= '0;
          top <= '0;
        end
        FSW_LOAD: begin
          cc  <= ld_cc;
          top <= ld_top;
        end
        FSW_UPDATE: begin
          if (upd_cc_we)  cc  <= upd_cc;
          if (upd_top_we) top <= upd_top;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fsw_mask_reg.sv
module fsw_mask_reg
  import fsw_pkg::*;
#(
  parameter int unsigned NUM_EXC = FSW_EXC_N
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init,
  input  logic               mask_we,
  input  logic [NUM_EXC-1:0] mask_in,
  output logic [NUM_EXC-1:0] mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '1;
    else if (init)    mask_q <= '1;
    else if (mask_we) mask_q <= mask_in;
  end
endmodule

// File: rtl/fsw_summary.sv
module fsw_summary #(
  parameter int unsigned NUM_EXC = 6
) (
  input  logic [NUM_EXC-1:0] flags,
  input  logic [NUM_EXC-1:0] mask_q,
  output logic               es
);
  function automatic logic unmasked_any(input logic [NUM_EXC-1:0] f,
                                        input logic [NUM_EXC-1:0] m);
    return |(f & ~m);
  endfunction

  assign es = unmasked_any(flags, mask_q);
endmodule

// File: rtl/fp_status_reg.sv
module fp_status_reg
  import fsw_pkg::*;
#(
  parameter int unsigned NUM_EXC = FSW_EXC_N,
  parameter int unsigned TOP_W   = FSW_TOP_W,
  localparam int unsigned SF_BIT  = NUM_EXC,
  localparam int unsigned ES_BIT  = NUM_EXC + 1,
  localparam int unsigned CC0_BIT = NUM_EXC + 2,
  localparam int unsigned TOP_LSB = CC0_BIT + 3,
  localparam int unsigned C3_BIT  = TOP_LSB + TOP_W,
  localparam int unsigned B_BIT   = C3_BIT + 1,
  localparam int unsigned WORD_W  = B_BIT + 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init,
  input  logic               ld_valid,
  input  logic [WORD_W-1:0]  ld_word,
  input  logic               clr_exc,
  input  logic               upd_valid,
  input  logic [NUM_EXC-1:0] upd_exc,
  input  logic               upd_stack_fault,
  input  logic               upd_cc_we,
  input  logic [3:0]         upd_cc,
  input  logic               upd_top_we,
  input  logic [TOP_W-1:0]   upd_top,
  input  logic               mask_we,
  input  logic [NUM_EXC-1:0] mask_in,
  output logic [WORD_W-1:0]  status_word,
  output logic               err_n
);
  fsw_cmd_e           cmd;
  logic [NUM_EXC-1:0] flags;
  logic [NUM_EXC-1:0] mask_q;
  logic               sf;
  logic               es;
  logic [3:0]         cc;
  logic [TOP_W-1:0]   top;
  logic [3:0]         ld_cc;

  assign cmd   = fsw_pick(init, ld_valid, clr_exc, upd_valid);
  assign ld_cc = {ld_word[C3_BIT], ld_word[CC0_BIT+2 -: 3]};

  fsw_flag_bank #(.NUM_EXC(NUM_EXC)) i_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (cmd),
    .upd_exc  (upd_exc),
    .upd_sf   (upd_stack_fault),
    .ld_flags (ld_word[NUM_EXC-1:0]),
    .ld_sf    (ld_word[SF_BIT]),
    .flags    (flags),
    .sf       (sf)
  );

  fsw_field_regs #(.TOP_W(TOP_W)) i_fields (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd        (cmd),
    .upd_cc_we  (upd_cc_we),
    .upd_cc     (upd_cc),
    .upd_top_we (upd_top_we),
    .upd_top    (upd_top),
    .ld_cc      (ld_cc),
    .ld_top     (ld_word[TOP_LSB +: TOP_W]),
    .cc         (cc),
    .top        (top)
  );

  fsw_mask_reg #(.NUM_EXC(NUM_EXC)) i_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .init    (init),
    .mask_we (mask_we),
    .mask_in (mask_in),
    .mask_q  (mask_q)
  );

  fsw_summary #(.NUM_EXC(NUM_EXC)) i_sum (
    .flags  (flags),
    .mask_q (mask_q),
    .es     (es)
  );

  // cc = {C3,C2,C1,C0}; B mirrors ES
  assign status_word = {es, cc[3], top, cc[2:0], es, sf, flags};
  assign err_n       = ~es;
endmodule

// File: rtl/fsw_checker.sv
module fsw_checker #(
  parameter int unsigned NUM_EXC = 6,
  parameter int unsigned TOP_W   = 3,
  localparam int unsigned SF_BIT  = NUM_EXC,
  localparam int unsigned ES_BIT  = NUM_EXC + 1,
  localparam int unsigned TOP_LSB = NUM_EXC + 5,
  localparam int unsigned WORD_W  = NUM_EXC + 7 + TOP_W
) (
  input logic               clk,
  input logic               rst_n,
  input logic               init,
  input logic               ld_valid,
  input logic [WORD_W-1:0]  ld_word,
  input logic               clr_exc,
  input logic               upd_valid,
  input logic               upd_top_we,
  input logic               mask_we,
  input logic [NUM_EXC-1:0] mask_in,
  input logic [WORD_W-1:0]  status_word,
  input logic               err_n
);
  AST_INIT_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> (status_word == '0) && err_n); // R1

  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && !ld_valid && !clr_exc) |=>
      ((status_word[NUM_EXC-1:0] & $past(status_word[NUM_EXC-1:0]))
        == $past(status_word[NUM_EXC-1:0]))); // R2

  AST_TOP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!init && !ld_valid && !(upd_valid && upd_top_we && !clr_exc)) |=>
      $stable(status_word[TOP_LSB +: TOP_W])); // R5

  AST_ALL_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_we && (&mask_in) && !init) |=> err_n); // R6

  AST_LOAD_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_valid && !init) |=>
      (status_word[SF_BIT:0] == $past(ld_word[SF_BIT:0]))); // R9

  AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_exc && !init && !ld_valid) |=>
      (status_word[ES_BIT:0] == '0) && err_n); // R10
endmodule

bind fp_status_reg fsw_checker #(.NUM_EXC(NUM_EXC), .TOP_W(TOP_W)) i_fsw_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .init        (init),
  .ld_valid    (ld_valid),
  .ld_word     (ld_word),
  .clr_exc     (clr_exc),
  .upd_valid   (upd_valid),
  .upd_top_we  (upd_top_we),
  .mask_we     (mask_we),
  .mask_in     (mask_in),
  .status_word (status_word),
  .err_n       (err_n)
);

// File: tb/test_fp_status_reg.sv
module test_fp_status_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        init = 1'b0, ld_valid = 1'b0, clr_exc = 1'b0, upd_valid = 1'b0;
  logic [15:0] ld_word = '0;
  logic [5:0]  upd_exc = '0;
  logic        upd_stack_fault = 1'b0, upd_cc_we = 1'b0, upd_top_we = 1'b0;
  logic [3:0]  upd_cc = '0;
  logic [2:0]  upd_top = '0;
  logic        mask_we = 1'b0;
  logic [5:0]  mask_in = '0;
  logic [15:0] status_word;
  logic        err_n;
  int          checks = 0, errors = 0;

  always #10 clk = ~clk;

  fp_status_reg i_fp_status_reg (
    .clk(clk), .rst_n(rst_n), .init(init), .ld_valid(ld_valid), .ld_word(ld_word),
    .clr_exc(clr_exc), .upd_valid(upd_valid), .upd_exc(upd_exc),
    .upd_stack_fault(upd_stack_fault), .upd_cc_we(upd_cc_we), .upd_cc(upd_cc),
    .upd_top_we(upd_top_we), .upd_top(upd_top), .mask_we(mask_we), .mask_in(mask_in),
    .status_word(status_word), .err_n(err_n)
  );

  // expected word: summary counted per flag, placed at bits 15 and 7
  function automatic logic [15:0] model(input logic [3:0] cc, input logic [2:0] top,
                                        input logic sf, input logic [5:0] fl,
                                        input logic [5:0] mk);
    int n = 0;
    logic s;
    for (int i = 0; i < 6; i++) if (fl[i] && !mk[i]) n++;
    s = (n > 0);
    return {s, cc[3], top, cc[2], cc[1], cc[0], s, sf, fl};
  endfunction

  task automatic chk(input string req, input logic [15:0] exp_w);
    checks++;
    if (status_word !== exp_w || err_n !== ~exp_w[7]) begin
      errors++;
      $display("FAIL %s: word=%h err_n=%b expected word=%h err_n=%b",
               req, status_word, err_n, exp_w, ~exp_w[7]);
    end
  endtask

  task automatic quiet();
    init = 0; ld_valid = 0; clr_exc = 0; upd_valid = 0; upd_exc = 0;
    upd_stack_fault = 0; upd_cc_we = 0; upd_top_we = 0; mask_we = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset", 16'h0000);

    // R2: masks all ones, flags accumulate without error
    upd_valid = 1; upd_exc = 6'b000101;
    @(negedge clk); quiet();
    chk("R2 first report", model(4'h0, 3'd0, 0, 6'b000101, 6'h3F));
    upd_valid = 1; upd_exc = 6'b010000;
    @(negedge clk); quiet();
    chk("R2 sticky merge", model(4'h0, 3'd0, 0, 6'b010101, 6'h3F));
    upd_valid = 1; upd_exc = 6'b000000;
    @(negedge clk); quiet();
    chk("R2 empty report keeps flags", model(4'h0, 3'd0, 0, 6'b010101, 6'h3F));

    // R12 / R7 / R8: unmask, flags unchanged, error raised
    mask_we = 1; mask_in = 6'b000000;
    @(negedge clk); quiet();
    chk("R12 mask write", model(4'h0, 3'd0, 0, 6'b010101, 6'h00));
    mask_we = 1; mask_in = 6'b010101;
    @(negedge clk); quiet();
    chk("R6 masked again", model(4'h0, 3'd0, 0, 6'b010101, 6'b010101));
    mask_we = 1; mask_in = 6'b010001;
    @(negedge clk); quiet();
    chk("R8 single unmasked flag", model(4'h0, 3'd0, 0, 6'b010101, 6'b010001));

    // R4 / R5 field updates
    upd_valid = 1; upd_cc_we = 1; upd_cc = 4'b1010; upd_top_we = 1; upd_top = 3'd5;
    @(negedge clk); quiet();
    chk("R4 R5 cc and top write", model(4'b1010, 3'd5, 0, 6'b010101, 6'b010001));
    upd_valid = 1; upd_cc = 4'b0101; upd_top = 3'd2;
    @(negedge clk); quiet();
    chk("R4 R5 disabled writes hold", model(4'b1010, 3'd5, 0, 6'b010101, 6'b010001));

    // R10 clear keeps cc/top
    clr_exc = 1;
    @(negedge clk); quiet();
    chk("R10 clear", model(4'b1010, 3'd5, 0, 6'b000000, 6'b010001));

    // R3 stack fault, overflow then underflow
    upd_valid = 1; upd_stack_fault = 1; upd_cc_we = 1; upd_cc = 4'b0010;
    @(negedge clk); quiet();
    chk("R3 overflow", model(4'b0010, 3'd5, 1, 6'b000001, 6'b010001));
    clr_exc = 1;
    @(negedge clk); quiet();
    upd_valid = 1; upd_stack_fault = 1; upd_cc_we = 1; upd_cc = 4'b0000;
    @(negedge clk); quiet();
    chk("R3 underflow", model(4'b0000, 3'd5, 1, 6'b000001, 6'b010001));

    // R11 priority
    upd_valid = 1; upd_exc = 6'h3F; clr_exc = 1;
    @(negedge clk); quiet();
    chk("R11 clear beats update", model(4'b0000, 3'd5, 0, 6'h00, 6'b010001));
    ld_valid = 1; ld_word = 16'h5A42; clr_exc = 1; upd_valid = 1; upd_exc = 6'h3F;
    @(negedge clk); quiet();
    chk("R11 load beats clear", model({1'b1, 3'b010}, 3'b011, 1, 6'b000010, 6'b010001));
    init = 1; ld_valid = 1; ld_word = 16'hFFFF; clr_exc = 1; upd_valid = 1;
    upd_exc = 6'h3F; mask_we = 1; mask_in = 6'h00;
    @(negedge clk); quiet();
    chk("R1 R11 init wins", 16'h0000);
    ld_valid = 1; ld_word = 16'h003F;
    @(negedge clk); quiet();
    chk("R1 masks all set after init", model(4'h0, 3'd0, 0, 6'h3F, 6'h3F));

    // R9 R6 R7 R8 exhaustive flags x masks through the load port
    for (int m = 0; m < 64; m++) begin
      for (int f = 0; f < 64; f++) begin
        logic [15:0] w;
        w = model({f[0], m[1:0], f[5]}, f[4:2], m[3], f[5:0], 6'h00);
        w[15] = ~w[15]; w[7] = ~w[7];      // garbage in the derived positions
        ld_valid = 1; ld_word = w; mask_we = 1; mask_in = m[5:0];
        @(negedge clk); quiet();
        chk("R9 R6 R7 R8 load sweep",
            model({f[0], m[1:0], f[5]}, f[4:2], m[3], f[5:0], m[5:0]));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule